// File: doc/BRIEF.md
# Extended-Address Add Execution Unit

This block takes a four-byte add instruction one byte per cycle over a valid/ready stream and carries it out against an internal register file of 4096 bytes. Two forms exist. Opcode 08h adds one register to another. Opcode 09h adds an 8-bit constant to a register. Operand addresses are 12 bits wide and are split across nibble boundaries of the instruction bytes. An address whose upper eight bits are EEh is an escape. It names a working register, and its final location comes from an 8-bit register pointer input.

After the last byte arrives, the unit stops accepting bytes. It reads both operands, writes the sum back to the destination one cycle later, updates six status flags, and pulses `done`. An opcode it does not know raises `illegal` for one cycle. The three bytes that follow it are thrown away, and nothing else changes. A test port can preset and inspect any register file location.

The controller is a single state machine with these states:
- OPCODE waits for the first byte. A known opcode leads to SRC and any other byte leads to BADOP.
- SRC, MID and DST each take one byte. DST leads to READ.
- READ latches the operands and leads to WRITE.
- WRITE stores the sum and the flags and leads to DONE.
- DONE pulses `done` and returns to OPCODE.
- BADOP pulses `illegal` and leads to SKIP.
- SKIP discards three bytes and returns to OPCODE.

Top module: `xadd_unit`

## Requirements
- R1: Opcode 08h takes the following bytes in this order: source address bits 11:4; then {source bits 3:0, destination bits 11:8}; then destination bits 7:0. It stores the 8-bit sum of the source and destination contents in the destination.
- R2: Opcode 09h takes the following bytes in this order: an immediate; then {0h, destination bits 11:8}; then destination bits 7:0. The immediate is used as the source value as-is, even when it equals EEh.
- R3: A source or destination address whose bits 11:4 equal EEh resolves to {rp[3:0], rp[7:4], address bits 3:0}. Every other address is used unchanged.
- R4: `flags` is {C,Z,S,V,H,D}, MSB first: C=bit5, Z=bit4, S=bit3, V=bit2, H=bit1, D=bit0. C is the carry out of bit 7, H is the carry out of bit 3, and D is cleared. `flags` changes only on the cycle on which `done` rises.
- R5: Z is set when the 8-bit sum is zero. S equals sum bit 7. V is set on two's-complement overflow, which is when the operands share a sign and the sum's sign differs from it.
- R6: Any other opcode raises `illegal` for exactly one cycle, starting one cycle after the opcode is accepted. The next three bytes are accepted and discarded. The flags and the register file stay unchanged, and the unit then waits for a new opcode.
- R7: `in_ready` is low from the cycle after the last instruction byte until `done`. `done` is high for exactly one cycle, on the third cycle after that last byte is accepted.
- R8: When `tst_we` is high, `tst_wdata` is written to `tst_addr` at the clock edge. `tst_rdata` always shows the contents at `tst_addr`, without a register stage.
- R9: After reset, `flags` is zero, `done` and `illegal` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit can accept a byte |
| rp | input | 8 | Register pointer: bits 3:0 select the page, bits 7:4 select the working group |
| tst_we | input | 1 | Test port write enable |
| tst_addr | input | 12 | Test port address |
| tst_wdata | input | 8 | Test port write data |
| tst_rdata | output | 8 | Test port read data |
| flags | output | 6 | Status flags {C,Z,S,V,H,D} |
| done | output | 1 | One-cycle pulse at the end of an instruction |
| illegal | output | 1 | One-cycle pulse on an unknown opcode |

## Verification
The bench checks every condition that sets a flag:
- A sum that wraps to zero must set C, Z and H together. A design with the carry taken at the wrong position reports C or H wrongly on values such as 2Eh+1Bh.
- 7Fh+01h and 80h+80h must set V. A design with a swapped overflow rule leaves V clear on them.

Escaped addresses are used as source, as destination and into page Eh. A nibble-swapped pointer mapping writes to the wrong location, and the bench sees that through the test port. An immediate of EEh must be added as plain data, not resolved as an address. After an illegal opcode, the bench sends an 08h byte among the discarded bytes. A unit that does not discard them would then misread the next real instruction.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_SRC,
        ST_MID,
        ST_DST,
        ST_BADOP,
        ST_SKIP,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } xadd_state_t;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic h;
        logic d;
    } xadd_flags_t;

endpackage

// File: rtl/xadd_resolve.sv
module xadd_resolve #(
    parameter int          ADDR_W  = 12,
    parameter int          NIB_W   = 4,
    parameter logic [7:0]  ESC_TAG = 8'hEE
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [7:0]        rp,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int TAG_W = ADDR_W - NIB_W;

    logic is_escape;

    always_comb begin
        is_escape = (raw_addr[ADDR_W-1:NIB_W] == ESC_TAG[TAG_W-1:0]);
        if (is_escape)
            eff_addr = {rp[NIB_W-1:0], rp[2*NIB_W-1:NIB_W], raw_addr[NIB_W-1:0]};
        else
            eff_addr = raw_addr;
    end
endmodule

// File: rtl/xadd_alu.sv
module xadd_alu
    import xadd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum,
    output xadd_flags_t       flg
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] wide;
    logic [HALF_W:0] low;

    always_comb begin
        wide  = {1'b0, opa} + {1'b0, opb};
        low   = {1'b0, opa[HALF_W-1:0]} + {1'b0, opb[HALF_W-1:0]};
        sum   = wide[DATA_W-1:0];
        flg.c = wide[DATA_W];
        flg.z = (wide[DATA_W-1:0] == '0);
        flg.s = wide[DATA_W-1];
        flg.v = (opa[DATA_W-1] == opb[DATA_W-1]) && (wide[DATA_W-1] != opa[DATA_W-1]);
        flg.h = low[HALF_W];
        flg.d = 1'b0;
    end
endmodule

// File: rtl/xadd_regfile.sv
module xadd_regfile #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int N_RD   = 3
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [N_RD-1:0][ADDR_W-1:0]    raddr,
    output logic [N_RD-1:0][DATA_W-1:0]    rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rdata[g] = cells[raddr[g]];
    end
endmodule

// File: rtl/xadd_unit.sv
module xadd_unit
    import xadd_pkg::*;
#(
    parameter int         ADDR_W  = 12,
    parameter int         DATA_W  = 8,
    parameter logic [7:0] OPC_RR  = 8'h08,
    parameter logic [7:0] OPC_IMM = 8'h09,
    parameter logic [7:0] ESC_TAG = 8'hEE,
    parameter int         DISCARD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic [7:0]        rp,
    input  logic              tst_we,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [DATA_W-1:0] tst_wdata,
    output logic [DATA_W-1:0] tst_rdata,
    output logic [5:0]        flags,
    output logic              done,
    output logic              illegal
);
    localparam int NIB_W  = 4;
    localparam int HI_W   = ADDR_W - 8;
    localparam int CNT_W  = $clog2(DISCARD + 1);
    localparam int N_RD   = 3;

    xadd_state_t state, nxt;

    logic              accept;
    logic              imm_form;
    logic [7:0]        b1, b2, b3;
    logic [CNT_W-1:0]  skip_cnt;
    logic [DATA_W-1:0] opa, opb;
    logic [ADDR_W-1:0] dst_q;
    xadd_flags_t       flg_q, alu_flg;
    logic [DATA_W-1:0] alu_sum;
    logic              exec_we;

    logic [ADDR_W-1:0] src_raw, dst_raw, src_eff, dst_eff;
    logic [N_RD-1:0][ADDR_W-1:0] rd_addr;
    logic [N_RD-1:0][DATA_W-1:0] rd_data;

    assign accept = in_valid && in_ready;

    // Operand address unpacking across nibble boundaries
    assign src_raw = {b1, b2[7:NIB_W]};
    assign dst_raw = {b2[HI_W-1:0], b3};

    xadd_resolve #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .ESC_TAG(ESC_TAG)) u_res_src (
        .raw_addr (src_raw),
        .rp       (rp),
        .eff_addr (src_eff)
    );

    xadd_resolve #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .ESC_TAG(ESC_TAG)) u_res_dst (
        .raw_addr (dst_raw),
        .rp       (rp),
        .eff_addr (dst_eff)
    );

    assign rd_addr = {tst_addr, dst_eff, src_eff};

    xadd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RD(N_RD)) u_rf (
        .clk   (clk),
        .we    (exec_we || tst_we),
        .waddr (exec_we ? dst_q : tst_addr),
        .wdata (exec_we ? alu_sum : tst_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign tst_rdata = rd_data[2];

    xadd_alu #(.DATA_W(DATA_W)) u_alu (
        .opa (opa),
        .opb (opb),
        .sum (alu_sum),
        .flg (alu_flg)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OPCODE;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPCODE: if (accept)
                           nxt = (in_byte == OPC_RR || in_byte == OPC_IMM) ? ST_SRC : ST_BADOP;
            ST_SRC:    if (accept) nxt = ST_MID;
            ST_MID:    if (accept) nxt = ST_DST;
            ST_DST:    if (accept) nxt = ST_READ;
            ST_BADOP:  nxt = ST_SKIP;
            ST_SKIP:   if (accept && skip_cnt == CNT_W'(DISCARD - 1)) nxt = ST_OPCODE;
            ST_READ:   nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_OPCODE;
            default:   nxt = ST_OPCODE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_ready = 1'b0;
        done     = 1'b0;
        illegal  = 1'b0;
        exec_we  = 1'b0;
        unique case (state)
            ST_OPCODE, ST_SRC, ST_MID, ST_DST, ST_SKIP: in_ready = 1'b1;
            ST_BADOP:  illegal = 1'b1;
            ST_WRITE:  exec_we = 1'b1;
            ST_DONE:   done    = 1'b1;
            default:   ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_form <= 1'b0;
            b1       <= '0;
            b2       <= '0;
            b3       <= '0;
            skip_cnt <= '0;
            opa      <= '0;
            opb      <= '0;
            dst_q    <= '0;
            flg_q    <= '0;
        end else begin
            unique case (state)
                ST_OPCODE: if (accept) imm_form <= (in_byte == OPC_IMM);
                ST_SRC:    if (accept) b1 <= in_byte;
                ST_MID:    if (accept) b2 <= in_byte;
                ST_DST:    if (accept) b3 <= in_byte;
                ST_BADOP:  skip_cnt <= '0;
                ST_SKIP:   if (accept) skip_cnt <= skip_cnt + 1'b1;
                ST_READ: begin
                    opa   <= imm_form ? b1 : rd_data[0];
                    opb   <= rd_data[1];
                    dst_q <= dst_eff;
                end
                ST_WRITE:  flg_q <= alu_flg;
                default:   ;
            endcase
        end
    end

    assign flags = flg_q;
endmodule

// File: rtl/xadd_checker.sv
module xadd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       done,
    input logic       illegal,
    input logic [5:0] flags
);
    AST_DONE_SINGLE:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);               // R7
    AST_BUSY_AT_DONE:      assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready);           // R7
    AST_ILLEGAL_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) illegal |=> !illegal);         // R6
    AST_ILLEGAL_KEEPS_FLG: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> $stable(flags));   // R6
    AST_PULSES_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, illegal}));    // R6
    AST_FLAGS_AT_DONE:     assert property (@(posedge clk) disable iff (!rst_n) !$stable(flags) |-> done);     // R4
    AST_DEC_CLEARED:       assert property (@(posedge clk) disable iff (!rst_n) done |-> !flags[0]);           // R4
    AST_ZERO_NOT_SIGNED:   assert property (@(posedge clk) disable iff (!rst_n) (done && flags[4]) |-> !flags[3]); // R5
endmodule

bind xadd_unit xadd_checker u_xadd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .done     (done),
    .illegal  (illegal),
    .flags    (flags)
);

// File: tb/tb_xadd_unit.sv
`timescale 1ns/1ps
module tb_xadd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic [7:0]  rp = '0;
    logic        tst_we = 1'b0;
    logic [11:0] tst_addr = '0;
    logic [7:0]  tst_wdata = '0;
    logic [7:0]  tst_rdata;
    logic [5:0]  flags;
    logic        done;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [4096];

    always #4 clk = ~clk;

    xadd_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rp(rp), .tst_we(tst_we), .tst_addr(tst_addr),
        .tst_wdata(tst_wdata), .tst_rdata(tst_rdata), .flags(flags),
        .done(done), .illegal(illegal)
    );

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] resolve(input logic [11:0] raw, input logic [7:0] p);
        return (raw[11:4] == 8'hEE) ? {p[3:0], p[7:4], raw[3:0]} : raw;
    endfunction

    function automatic logic [13:0] exp_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        logic [4:0] lo;
        logic [5:0] f;
        s  = {1'b0, a} + {1'b0, b};
        lo = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        f  = {s[8], s[7:0] == 8'h00, s[7], (a[7] == b[7]) && (s[7] != a[7]), lo[4], 1'b0};
        return {f, s[7:0]};
    endfunction

    task automatic tst_write(input logic [11:0] a, input logic [7:0] d);
        tst_we = 1'b1; tst_addr = a; tst_wdata = d;
        @(negedge clk);
        tst_we = 1'b0;
        model[a] = d;
    endtask

    task automatic tst_read(input logic [11:0] a, output logic [7:0] d);
        tst_addr = a;
        #1;
        d = tst_rdata;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Runs one instruction and checks timing, flags and the stored sum
    task automatic run_insn(input logic imm, input logic [7:0] srcv, input logic [11:0] sraw,
                            input logic [11:0] draw, input string tag);
        logic [11:0] sres, dres;
        logic [7:0]  a, b, got;
        logic [13:0] e;
        sres = resolve(sraw, rp);
        dres = resolve(draw, rp);
        a = imm ? srcv : model[sres];
        b = model[dres];
        e = exp_add(a, b);
        if (imm) begin
            send(8'h09); send(srcv); send({4'h0, draw[11:8]}); send(draw[7:0]);
        end else begin
            send(8'h08); send(sraw[11:4]); send({sraw[3:0], draw[11:8]}); send(draw[7:0]);
        end
        chk({"R7 ready low after last byte ", tag}, {31'd0, in_ready}, 0);
        chk({"R7 done not early ", tag}, {31'd0, done}, 0);
        @(negedge clk);
        @(negedge clk);
        chk({"R7 done on third cycle ", tag}, {31'd0, done}, 1);
        chk({"R4 R5 flags ", tag}, {26'd0, flags}, {26'd0, e[13:8]});
        tst_read(dres, got);
        chk({"R1 R2 R3 sum at destination ", tag}, {24'd0, got}, {24'd0, e[7:0]});
        model[dres] = e[7:0];
        @(negedge clk);
        chk({"R7 done single cycle ", tag}, {31'd0, done}, 0);
    endtask

    initial begin
        logic [7:0] rd;
        logic [5:0] saved;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 flags reset", {26'd0, flags}, 0);
        chk("R9 done reset", {31'd0, done}, 0);
        chk("R9 illegal reset", {31'd0, illegal}, 0);
        chk("R9 ready reset", {31'd0, in_ready}, 1);

        // R8 test port
        tst_write(12'h5A5, 8'hC3);
        tst_read(12'h5A5, rd);
        chk("R8 test port readback", {24'd0, rd}, 32'hC3);

        // R1 directed: 2Eh + 1Bh = 49h, H only
        tst_write(12'h634, 8'h2E); tst_write(12'hB12, 8'h1B);
        run_insn(1'b0, 8'h00, 12'hB12, 12'h634, "R1 dir 2E+1B");
        chk("R4 H only on 2E+1B", {26'd0, flags}, 32'h02);
        // R5 wrap to zero: C Z H
        tst_write(12'h100, 8'hFF); tst_write(12'h101, 8'h01);
        run_insn(1'b0, 8'h00, 12'h101, 12'h100, "R5 FF+01");
        // R5 signed overflow positive
        tst_write(12'h102, 8'h7F);
        run_insn(1'b1, 8'h01, 12'h000, 12'h102, "R5 7F+01");
        // R5 overflow negative
        tst_write(12'h103, 8'h80);
        run_insn(1'b1, 8'h80, 12'h000, 12'h103, "R5 80+80");
        // R2 immediate EEh used as data
        tst_write(12'h104, 8'h10);
        run_insn(1'b1, 8'hEE, 12'h000, 12'h104, "R2 imm EE");
        // R3 escape destination into page E
        rp = 8'h3E;
        tst_write(12'hE34, 8'h2E); tst_write(12'hB12, 8'h1B);
        run_insn(1'b0, 8'h00, 12'hB12, 12'hEE4, "R3 escaped dst page E");
        // R3 escape source
        rp = 8'hA5;
        tst_write(12'h5A7, 8'h41); tst_write(12'h222, 8'h02);
        run_insn(1'b0, 8'h00, 12'hEE7, 12'h222, "R3 escaped src");

        // R6 illegal opcode, discarded bytes include 08h
        saved = flags;
        tst_write(12'h812, 8'h55);
        send(8'h5A);
        chk("R6 illegal pulse", {31'd0, illegal}, 1);
        chk("R6 not ready during illegal", {31'd0, in_ready}, 0);
        send(8'h08); send(8'h81); send(8'h28);
        chk("R6 illegal single", {31'd0, illegal}, 0);
        chk("R6 flags unchanged", {26'd0, flags}, {26'd0, saved});
        tst_read(12'h812, rd);
        chk("R6 regfile unchanged", {24'd0, rd}, 32'h55);
        chk("R6 ready for new opcode", {31'd0, in_ready}, 1);
        tst_write(12'h300, 8'h11);
        run_insn(1'b1, 8'h22, 12'h000, 12'h300, "R6 after discard");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [11:0] s, d;
            logic        im;
            logic [7:0]  iv;
            rp = 8'($urandom);
            im = 1'($urandom);
            iv = ($urandom % 8 == 0) ? 8'hEE : 8'($urandom);
            s  = 12'($urandom); d = 12'($urandom);
            if ($urandom % 3 == 0) s[11:4] = 8'hEE;
            if ($urandom % 3 == 0) d[11:4] = 8'hEE;
            tst_write(resolve(s, rp), 8'($urandom));
            tst_write(resolve(d, rp), 8'($urandom));
            run_insn(im, iv, s, d, im ? "R2 random" : "R1 R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule